// File: doc/BRIEF.md
# Transmit Collision Retry Limiter

This block counts the collision-driven retransmissions of one outgoing frame in a half-duplex CSMA/CD Ethernet transmitter. It decides when the frame must be abandoned for excessive collisions, and it controls how transmission resumes after such an abort. The MAC raises `frame_start` when it begins a new frame. It pulses `collision` whenever the medium reports a collision and pulses `tx_ok` when the frame has gone out cleanly. The block answers each collision in one of two ways: it requests a retransmission, or it aborts and raises the error flags.

The abort threshold is programmable through a 4-bit multiplier `retry_mult`, which is latched at the start of each frame. The permitted number of retransmissions is 16 × (multiplier + 1). The smallest limit is therefore 16 retries and the largest is 256.

After an abort, software has two ways out. It can issue `clr_abort`, which resends the aborted frame with its counter cleared and the limit unchanged. It can also start a fresh frame. The backoff timing, the framing and the descriptor traffic belong to neighbouring logic.

Top module: `tx_retry_limiter`

## Requirements
- R1: After reset, `state_o` is IDLE (encoding IDLE=0, SENDING=1, RETRY_WAIT=2, ABORTED=3), and `retx_req`, `tx_err_irq` and `tx_err_desc` are all low.
- R2: A `frame_start` seen in IDLE or ABORTED moves the block to SENDING, clears the retry count and latches `retry_mult`.
- R3: A `collision` seen in SENDING while the retry count is below the limit adds one to the count. The block then spends exactly one cycle in RETRY_WAIT with `retx_req` high, and returns to SENDING.
- R4: With a latched multiplier of 0, the first 16 collisions of a frame produce retries, and the 17th collision aborts the frame.
- R5: With a latched multiplier of N, the frame is aborted on collision number 16 + 16·N + 1. For N=15 this means 256 retries.
- R6: On abort, the block enters ABORTED. `tx_err_irq` is high for exactly that first cycle. `tx_err_desc` stays high for as long as the block remains in ABORTED.
- R7: A change of `retry_mult` after `frame_start` has no effect on the limit of the current frame. This includes a restart through `clr_abort`, which keeps the latched limit.
- R8: A `tx_ok` seen in SENDING returns the block to IDLE and clears the retry count. `tx_ok` wins over a simultaneous `collision`.
- R9: A `clr_abort` seen in ABORTED returns the block to SENDING with the retry count cleared and `tx_err_desc` low. `clr_abort` wins over a simultaneous `frame_start`.
- R10: `clr_abort` is ignored in every state other than ABORTED. In particular, it neither changes the state nor clears the retry count.
- R11: In ABORTED, `collision` and `tx_ok` are ignored. Only `frame_start` or `clr_abort` leaves that state.
- R12: `collision` and `tx_ok` are ignored in IDLE. A `collision` seen in RETRY_WAIT is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_start | input | 1 | Start-of-frame strobe |
| collision | input | 1 | Collision-detected strobe |
| tx_ok | input | 1 | Transmit-success strobe |
| retry_mult | input | 4 | Retry multiplier; limit is 16·(value+1) |
| clr_abort | input | 1 | Restart the aborted frame (honoured only in ABORTED) |
| retx_req | output | 1 | Retransmit request, one cycle per accepted collision |
| tx_err_irq | output | 1 | One-cycle excessive-collision pulse to interrupt status |
| tx_err_desc | output | 1 | Excessive-collision flag to descriptor status, held while aborted |
| state_o | output | 2 | Current state (IDLE=0, SENDING=1, RETRY_WAIT=2, ABORTED=3) |

## Verification
The bench pushes frames exactly to their limits, with multipliers of 0, 2 and 15. An off-by-one in the comparison would show up as an abort one collision early or one collision late. A counter that is too narrow would wrap and never abort at 256.

The bench also changes the multiplier in the middle of a frame and just before a clear-abort. A design that failed to latch the multiplier would then abort at the wrong count.

It issues clear-abort in IDLE and in SENDING, and follows that with a count that must run on from where it was. A design that honoured the command outside ABORTED would reset the counter and abort late.

Finally, the bench holds collisions across the RETRY_WAIT cycle, and sends collisions and success strobes while the block is aborted. Either of these would expose double counting, or a design that leaves ABORTED on its own.

// File: rtl/tx_retry_limiter.sv
module tx_retry_limiter #(
  parameter int MULT_W   = 4,
  parameter int STEP_LOG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_start,
  input  logic              collision,
  input  logic              tx_ok,
  input  logic [MULT_W-1:0] retry_mult,
  input  logic              clr_abort,
  output logic              retx_req,
  output logic              tx_err_irq,
  output logic              tx_err_desc,
  output logic [1:0]        state_o
);

  localparam int CNT_W = MULT_W + STEP_LOG + 1;

  typedef enum logic [1:0] {S_IDLE = 2'd0, S_SEND = 2'd1, S_WAIT = 2'd2, S_ABORT = 2'd3} st_t;

  st_t               state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [MULT_W-1:0] mult_q;
  logic              irq_q, desc_q;
  logic [CNT_W-1:0]  limit;

  assign limit       = ({{(CNT_W-MULT_W){1'b0}}, mult_q} + CNT_W'(1)) << STEP_LOG;
  assign retx_req    = (state_q == S_WAIT);
  assign tx_err_irq  = irq_q;
  assign tx_err_desc = desc_q;
  assign state_o     = state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      cnt_q   <= '0;
      mult_q  <= '0;
      irq_q   <= 1'b0;
      desc_q  <= 1'b0;
    end else begin
      irq_q <= 1'b0;
      case (state_q)
        S_IDLE: if (frame_start) begin
          state_q <= S_SEND;
          cnt_q   <= '0;
          mult_q  <= retry_mult;
        end
        S_SEND: begin
          if (tx_ok) begin
            state_q <= S_IDLE;
            cnt_q   <= '0;
          end else if (collision) begin
            if (cnt_q == limit) begin
              state_q <= S_ABORT;
              irq_q   <= 1'b1;
              desc_q  <= 1'b1;
            end else begin
              cnt_q   <= cnt_q + CNT_W'(1);
              state_q <= S_WAIT;
            end
          end
        end
        S_WAIT: state_q <= S_SEND;
        S_ABORT: begin
          if (clr_abort) begin
            state_q <= S_SEND;
            cnt_q   <= '0;
            desc_q  <= 1'b0;
          end else if (frame_start) begin
            state_q <= S_SEND;
            cnt_q   <= '0;
            mult_q  <= retry_mult;
            desc_q  <= 1'b0;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  p_retx_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    retx_req |=> !retx_req && state_q == S_SEND);

  p_cnt_within_limit_r5: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= limit);

  p_irq_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_irq |=> !tx_err_irq);

  p_irq_in_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_irq |-> tx_err_desc && state_q == S_ABORT);

  p_desc_only_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_err_desc |-> state_q == S_ABORT);

  p_limit_frozen_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |=> $stable(mult_q));

  p_clr_outside_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_IDLE && clr_abort && !frame_start) |=> state_q == S_IDLE);

  p_abort_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_ABORT && !frame_start && !clr_abort) |=> state_q == S_ABORT);

endmodule

// File: tb/test_tx_retry_limiter.sv
module test_tx_retry_limiter;
  logic clk = 1'b0, rst_n = 1'b0;
  logic frame_start = 0, collision = 0, tx_ok = 0, clr_abort = 0;
  logic [3:0] retry_mult = 0;
  logic retx_req, tx_err_irq, tx_err_desc;
  logic [1:0] state_o;
  int checks = 0, fails = 0;

  localparam logic [1:0] IDLE = 2'd0, SEND = 2'd1, WAITS = 2'd2, ABRT = 2'd3;

  always #5 clk = ~clk;

  tx_retry_limiter i_tx_retry_limiter (
    .clk, .rst_n, .frame_start, .collision, .tx_ok, .retry_mult, .clr_abort,
    .retx_req, .tx_err_irq, .tx_err_desc, .state_o);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic chk_out(input string req, input logic [1:0] st, input logic rq,
                         input logic irq, input logic desc);
    chk(state_o == st, req, state_o, st);
    chk({retx_req, tx_err_irq, tx_err_desc} == {rq, irq, desc}, req,
        {retx_req, tx_err_irq, tx_err_desc}, {rq, irq, desc});
  endtask

  task automatic pulse_start(input logic [3:0] m);
    @(negedge clk); retry_mult = m; frame_start = 1;
    @(negedge clk); frame_start = 0;
    chk_out("R2", SEND, 0, 0, 0);
  endtask

  // one collision; width 2 holds it into RETRY_WAIT (R12)
  task automatic hit(input bit expect_abort, input int width, input string req);
    @(negedge clk); collision = 1;
    @(negedge clk);
    if (width == 1) collision = 0;
    if (expect_abort) begin
      chk_out(req, ABRT, 0, 1, 1);
      @(negedge clk); collision = 0;
      chk_out("R6", ABRT, 0, 0, 1);
    end else begin
      chk_out(req, WAITS, 1, 0, 0);
      @(negedge clk); collision = 0;
      chk(state_o == SEND && !retx_req, "R3", state_o, SEND);
    end
  endtask

  task automatic run_to_abort(input int retries, input string req);
    for (int i = 0; i < retries; i++) hit(0, 1, req);
    hit(1, 1, req);
  endtask

  task automatic t_reset;
    chk_out("R1", IDLE, 0, 0, 0);
  endtask

  task automatic t_mult0;
    pulse_start(4'd0);
    run_to_abort(16, "R4");
  endtask

  task automatic t_abort_hold_and_clear;
    @(negedge clk); collision = 1; tx_ok = 1;
    @(negedge clk); collision = 0; tx_ok = 0;
    chk_out("R11", ABRT, 0, 0, 1);
    @(negedge clk); retry_mult = 4'd3; clr_abort = 1; frame_start = 1;
    @(negedge clk); clr_abort = 0; frame_start = 0;
    chk_out("R9", SEND, 0, 0, 0);
    run_to_abort(16, "R7");
  endtask

  task automatic t_multn;
    pulse_start(4'd2);
    retry_mult = 4'd0;
    run_to_abort(48, "R5");
    pulse_start(4'd15);
    run_to_abort(256, "R5");
  endtask

  task automatic t_success;
    pulse_start(4'd0);
    for (int i = 0; i < 10; i++) hit(0, 1, "R8");
    @(negedge clk); tx_ok = 1; collision = 1;
    @(negedge clk); tx_ok = 0; collision = 0;
    chk_out("R8", IDLE, 0, 0, 0);
    pulse_start(4'd0);
    run_to_abort(16, "R8");
  endtask

  task automatic t_clr_ignored;
    @(negedge clk); frame_start = 1;
    @(negedge clk); frame_start = 0; tx_ok = 1;
    @(negedge clk); tx_ok = 0;
    chk_out("R10", IDLE, 0, 0, 0);
    @(negedge clk); clr_abort = 1;
    @(negedge clk); clr_abort = 0;
    chk_out("R10", IDLE, 0, 0, 0);
    @(negedge clk); collision = 1; tx_ok = 1;
    @(negedge clk); collision = 0; tx_ok = 0;
    chk_out("R12", IDLE, 0, 0, 0);
    pulse_start(4'd0);
    for (int i = 0; i < 5; i++) hit(0, 1, "R10");
    @(negedge clk); clr_abort = 1;
    @(negedge clk); clr_abort = 0;
    chk_out("R10", SEND, 0, 0, 0);
    run_to_abort(11, "R10");
  endtask

  task automatic t_wait_collision;
    pulse_start(4'd0);
    for (int i = 0; i < 16; i++) hit(0, 2, "R12");
    hit(1, 1, "R12");
  endtask

  initial begin
    #1000000;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #2 t_reset();
    #20 rst_n = 1;
    t_reset();
    t_mult0();
    t_abort_hold_and_clear();
    t_multn();
    t_success();
    t_clr_ignored();
    t_wait_collision();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule